// File: doc/BRIEF.md
# GPIO Controller with Edge and Level Interrupts

A memory-mapped general-purpose I/O block for up to 32 pins, reached through a single-cycle register port (write strobe, byte address, write data, combinational read data). Each pin has an input enable, an output enable, a stored output value and an output inversion mask. The value driven on a pin is the stored output XORed with the mask. The block reads back the pin level through an internal loopback, with an optional external input ORed onto each pin.

The sampled pin level passes through a synchronizer. The block then detects four interrupt kinds on it: rising edge, falling edge, high level and low level. Each kind has an enable register and a pending register. A write of ones to a pending register clears those bits. A level pending bit sets itself again while its condition holds. One interrupt line combines every enabled pending bit and goes to the system interrupt controller.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_o` and `pin_oe_o` are 0 and `irq_o` is 0.
- R2: `pin_o` equals output value (byte offset 0x0C) XOR inversion mask (0x40), and `pin_oe_o` equals output enable (0x08), from the cycle after the write.
- R3: Input value (0x00) reads `((pin_o & pin_oe_o) | ext_i) & input_enable` (enable at 0x04), delayed by the two-flop synchronizer. It changes on the second clock edge after the edge that wrote the register. Writing the output enable never alters the stored output value.
- R4: A rising (falling) edge of the synchronized input sets the matching bit of the rise pending register 0x1C (fall pending 0x24), but only where rise enable 0x18 (fall enable 0x20) is 1. The bit is set one edge after the new input value becomes readable.
- R5: While a synchronized input bit is 1 (0) and its high enable 0x28 (low enable 0x30) bit is 1, the high pending 0x2C (low pending 0x34) bit is set on every edge, so clearing it has no lasting effect.
- R6: Writing 1 to a pending bit clears it; writing 0 leaves it unchanged; a set event on the same edge as the clear wins.
- R7: Changes on pins whose input enable is 0 create no rise, fall, high or low pending bit.
- R8: Writing the inversion mask produces rise and fall events exactly as writing the output value does.
- R9: `irq_o` is 1 exactly when some pending bit of some kind has its enable bit set; clearing an enable drops `irq_o` while the pending bit stays.
- R10: `ext_i` drives the sampled level of a pin whose output enable is 0 and raises edge events like a driven pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| ext_i | input | NPINS | External level ORed onto each pin |
| pin_o | output | NPINS | Value driven on each pin |
| pin_oe_o | output | NPINS | Pin driver enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives pins through mixed enable patterns. In these, one write disables outputs or inputs on high pins and creates falls, and another toggles only disabled pins. A design that gated the input after the synchronizer, or ignored output enable on loopback, would report or miss the wrong events there. Directed cases count edges to pin the exact two- and three-edge latency. They collide a clear with a set event on the same edge, where a clear-wins design loses the event. They check that a cleared level bit reappears at once, that a zero write clears nothing, and that `irq_o` follows the enables and not only the pending bits.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned KINDS  = 4;

  localparam int KIND_RISE = 0;
  localparam int KIND_FALL = 1;
  localparam int KIND_HIGH = 2;
  localparam int KIND_LOW  = 3;

  localparam logic [ADDR_W-1:0] OFF_IN  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_IEN = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_OEN = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_OUT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_XOR = 8'h40;

  // enable/pending pairs sit 8 bytes apart, starting at 0x18
  function automatic logic [ADDR_W-1:0] ie_off(int k);
    return ADDR_W'(32'h18 + 32'(8 * k));
  endfunction

  function automatic logic [ADDR_W-1:0] ip_off(int k);
    return ADDR_W'(32'h1C + 32'(8 * k));
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_evt.sv
`timescale 1ns/1ps
module gpio_evt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] high_o,
  output logic [W-1:0] low_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  assign rise_o = sync_i & ~prev_q;
  assign fall_o = ~sync_i & prev_q;
  assign high_o = sync_i;
  assign low_o  = ~sync_i;
endmodule

// File: rtl/gpio_pend.sv
`timescale 1ns/1ps
module gpio_pend #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] ip_o
);
  logic [W-1:0] ip_q;

  // set beats clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ip_q <= '0;
    else         ip_q <= (ip_q & ~clr_i) | set_i;
  end

  assign ip_o = ip_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NPINS-1:0]  ext_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] wdata_n;
  logic [NPINS-1:0] ien_q, oen_q, out_q, xor_q;
  logic [NPINS-1:0] drive, raw_in, sync_in;
  logic [NPINS-1:0] kind_ie_q [KINDS];
  logic [NPINS-1:0] kind_ev   [KINDS];
  logic [NPINS-1:0] kind_clr  [KINDS];
  logic [NPINS-1:0] kind_ip   [KINDS];

  assign wdata_n = wdata_i[NPINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      oen_q <= '0;
      out_q <= '0;
      xor_q <= '0;
      for (int k = 0; k < int'(KINDS); k++) kind_ie_q[k] <= '0;
    end else if (we_i) begin
      if (addr_i == OFF_IEN) ien_q <= wdata_n;
      if (addr_i == OFF_OEN) oen_q <= wdata_n;
      if (addr_i == OFF_OUT) out_q <= wdata_n;
      if (addr_i == OFF_XOR) xor_q <= wdata_n;
      for (int k = 0; k < int'(KINDS); k++)
        if (addr_i == ie_off(k)) kind_ie_q[k] <= wdata_n;
    end
  end

  assign drive    = out_q ^ xor_q;
  assign pin_o    = drive;
  assign pin_oe_o = oen_q;
  // gate before the synchronizer so disabled pins never toggle it
  assign raw_in   = ((drive & oen_q) | ext_i) & ien_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  gpio_evt #(.W(NPINS)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_in),
    .rise_o(kind_ev[KIND_RISE]),
    .fall_o(kind_ev[KIND_FALL]),
    .high_o(kind_ev[KIND_HIGH]),
    .low_o (kind_ev[KIND_LOW])
  );

  for (genvar k = 0; k < int'(KINDS); k++) begin : g_kind
    assign kind_clr[k] = (we_i && addr_i == ip_off(k)) ? wdata_n : '0;
    gpio_pend #(.W(NPINS)) u_pend (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (kind_ev[k] & kind_ie_q[k]),
      .clr_i (kind_clr[k]),
      .ip_o  (kind_ip[k])
    );
  end

  always_comb begin
    logic [NPINS-1:0] act;
    act = '0;
    for (int k = 0; k < int'(KINDS); k++) act |= kind_ip[k] & kind_ie_q[k];
    irq_o = |act;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_IN:  rdata_o = REG_W'(sync_in);
      OFF_IEN: rdata_o = REG_W'(ien_q);
      OFF_OEN: rdata_o = REG_W'(oen_q);
      OFF_OUT: rdata_o = REG_W'(out_q);
      OFF_XOR: rdata_o = REG_W'(xor_q);
      default: rdata_o = '0;
    endcase
    for (int k = 0; k < int'(KINDS); k++) begin
      if (addr_i == ie_off(k)) rdata_o = REG_W'(kind_ie_q[k]);
      if (addr_i == ip_off(k)) rdata_o = REG_W'(kind_ip[k]);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic              irq_o,
  input logic [W-1:0]      pin_o,
  input logic [W-1:0]      out_q,
  input logic [W-1:0]      xor_q,
  input logic [W-1:0]      sync_in,
  input logic [W-1:0]      rise_ev,
  input logic [W-1:0]      rise_ie,
  input logic [W-1:0]      high_ie,
  input logic [W-1:0]      rise_ip,
  input logic [W-1:0]      fall_ip,
  input logic [W-1:0]      high_ip,
  input logic [W-1:0]      low_ip
);
  AST_OUT_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_OUT) |=> ((pin_o ^ $past(wdata_i[W-1:0])) == xor_q)); // R2
  AST_OE_KEEPS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_OEN) |=> $stable(out_q)); // R3
  AST_RISE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rise_ip & ~$past(rise_ip) & ~$past(rise_ie)) == '0)); // R4
  AST_HIGH_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(high_ie & sync_in)) |=> ((high_ip & $past(high_ie & sync_in)) == $past(high_ie & sync_in))); // R5
  AST_RISE_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ip_off(KIND_RISE)) |=> ((rise_ip & $past(wdata_i[W-1:0]) & ~$past(rise_ev)) == '0)); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(rise_ip | fall_ip | high_ip | low_ip))); // R9
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(NPINS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .pin_o  (pin_o),
  .out_q  (out_q),
  .xor_q  (xor_q),
  .sync_in(sync_in),
  .rise_ev(kind_ev[0]),
  .rise_ie(kind_ie_q[0]),
  .high_ie(kind_ie_q[2]),
  .rise_ip(kind_ip[0]),
  .fall_ip(kind_ip[1]),
  .high_ip(kind_ip[2]),
  .low_ip (kind_ip[3])
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] ext_i = '0;
  logic [31:0] pin_o, pin_oe_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_irq_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_i(ext_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  localparam logic [7:0] A_IN = 8'h00, A_IEN = 8'h04, A_OEN = 8'h08, A_OUT = 8'h0C,
                         A_RIE = 8'h18, A_RIP = 8'h1C, A_FIE = 8'h20, A_FIP = 8'h24,
                         A_HIE = 8'h28, A_HIP = 8'h2C, A_LIE = 8'h30, A_LIP = 8'h34,
                         A_XOR = 8'h40;

  // rows: {rise_en, fall_en, in_en, out_en, out_val, xor_mask}
  localparam int NV = 6;
  localparam logic [191:0] VEC [NV] = '{
    {32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF, 32'hFFFFFFFF, 32'hF0F00001, 32'h00000000},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFF0000, 32'hFF0000FF, 32'h0F0F0F0F, 32'h00000000},
    {32'h0000FFFF, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h33FFFF33, 32'h00000000},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 32'hFF0000FF, 32'h00000000, 32'hFFFFFFFF},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h33333333},
    {32'h00000000, 32'h0000FFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hCCCCCCCC, 32'h00000000}
  };

  // bench model of the requirements
  logic [31:0] m_ien = '0, m_oen = '0, m_out = '0, m_xor = '0;
  logic [31:0] m_rie = '0, m_fie = '0, m_hie = '0, m_lie = '0;
  logic [31:0] m_rip = '0, m_fip = '0, m_hip = '0, m_lip = '0;
  logic [31:0] m_in = '0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step_model();
    logic [31:0] nx;
    nx = (((m_out ^ m_xor) & m_oen) | ext_i) & m_ien;
    m_rip |= nx & ~m_in & m_rie;
    m_fip |= ~nx & m_in & m_fie;
    m_hip |= nx & m_hie;
    m_lip |= ~nx & m_lie;
    m_in = nx;
  endtask

  task automatic raw_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_i);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    raw_wr(a, d);
    case (a)
      A_IEN: m_ien = d;
      A_OEN: m_oen = d;
      A_OUT: m_out = d;
      A_XOR: m_xor = d;
      A_RIE: m_rie = d;
      A_FIE: m_fie = d;
      A_HIE: m_hie = d;
      A_LIE: m_lie = d;
      A_RIP: m_rip &= ~d;
      A_FIP: m_fip &= ~d;
      A_HIP: m_hip &= ~d;
      A_LIP: m_lip &= ~d;
      default: ;
    endcase
    settle();
    step_model();
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    we_i = 1'b0; addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic clear_all();
    wr(A_RIP, 32'hFFFFFFFF); wr(A_FIP, 32'hFFFFFFFF);
    wr(A_HIP, 32'hFFFFFFFF); wr(A_LIP, 32'hFFFFFFFF);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    for (int a = 0; a <= 16; a++) begin
      rd(8'(a * 4), r);
      chk("R1", $sformatf("reg %h after reset", a * 4), r, 32'h0);
    end
    chk("R1", "pin_o reset", pin_o, 32'h0);
    chk("R1", "pin_oe_o reset", pin_oe_o, 32'h0);
    chk("R1", "irq reset", {31'h0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    settle();

    // table walk: R2 R3 R4 R7 R8
    for (int v = 0; v < NV; v++) begin
      clear_all();
      wr(A_RIE, VEC[v][191:160]);
      wr(A_FIE, VEC[v][159:128]);
      wr(A_IEN, VEC[v][127:96]);
      wr(A_OEN, VEC[v][95:64]);
      wr(A_OUT, VEC[v][63:32]);
      wr(A_XOR, VEC[v][31:0]);
      rd(A_IN, r);  chk("R3/R7", $sformatf("vec %0d input", v), r, m_in);
      rd(A_RIP, r); chk("R4/R7/R8", $sformatf("vec %0d rise pending", v), r, m_rip);
      rd(A_FIP, r); chk("R4/R7/R8", $sformatf("vec %0d fall pending", v), r, m_fip);
      rd(A_OUT, r); chk("R3", $sformatf("vec %0d stored out", v), r, m_out);
      chk("R2", $sformatf("vec %0d pin_o", v), pin_o, m_out ^ m_xor);
      chk("R2", $sformatf("vec %0d pin_oe_o", v), pin_oe_o, m_oen);
    end

    // clean state for directed tests
    wr(A_XOR, 0); wr(A_OUT, 0); wr(A_RIE, 0); wr(A_FIE, 0);
    wr(A_IEN, 32'hFFFFFFFF); wr(A_OEN, 32'hFFFFFFFF);
    clear_all();
    wr(A_RIE, 32'hFFFFFFFF);

    // R3/R4: latency counted in edges
    raw_wr(A_OUT, 32'h1);
    @(negedge clk_i);
    rd(A_IN, r);  chk("R3", "input one edge after write", r, 32'h0);
    @(negedge clk_i);
    rd(A_IN, r);  chk("R3", "input two edges after write", r, 32'h1);
    rd(A_RIP, r); chk("R4", "rise pending not yet", r, 32'h0);
    @(negedge clk_i);
    rd(A_RIP, r); chk("R4", "rise pending one edge later", r, 32'h1);
    settle();
    m_out = 32'h1; step_model();

    // R6: write 0 changes nothing
    wr(A_RIP, 32'h0);
    rd(A_RIP, r); chk("R6", "zero write keeps pending", r, 32'h1);

    // R6: set on same edge as clear wins
    raw_wr(A_OUT, 32'h3);
    @(negedge clk_i);
    raw_wr(A_RIP, 32'hFFFFFFFF);
    rd(A_RIP, r); chk("R6", "set wins over clear", r, 32'h2);
    settle();
    m_out = 32'h3; m_in = 32'h3; m_rip = 32'h2;

    // R9: irq follows enables
    chk("R9", "irq with enabled pending", {31'h0, irq_o}, 32'h1);
    wr(A_RIE, 32'h0);
    chk("R9", "irq dropped by enable", {31'h0, irq_o}, 32'h0);
    rd(A_RIP, r); chk("R9", "pending kept after enable off", r, 32'h2);
    wr(A_RIP, 32'hFFFFFFFF);

    // R5: level re-arm
    wr(A_HIE, 32'h0000000F);
    rd(A_HIP, r); chk("R5", "high pending", r, m_hip);
    wr(A_HIP, 32'hFFFFFFFF);
    rd(A_HIP, r); chk("R5", "high pending re-armed", r, 32'h3);
    wr(A_LIE, 32'h0000000F);
    wr(A_LIP, 32'hFFFFFFFF);
    rd(A_LIP, r); chk("R5", "low pending re-armed", r, 32'hC);
    wr(A_HIE, 0); wr(A_LIE, 0);
    clear_all();
    rd(A_HIP, r); chk("R5", "high pending clears once disabled", r, 32'h0);

    // R10: external input on undriven pin
    wr(A_OEN, 32'hFFFF0000);
    wr(A_RIE, 32'hFFFFFFFF);
    ext_i = 32'h00000100;
    settle(); step_model();
    rd(A_IN, r);  chk("R10", "ext input read", r, 32'h00000100);
    rd(A_RIP, r); chk("R10", "ext rise pending", r, m_rip);
    chk("R10", "ext rise bit", r & 32'h100, 32'h100);
    // R7: ext change on disabled input creates nothing
    wr(A_IEN, 32'hFFFFFEFF);
    wr(A_FIE, 0);
    clear_all();
    ext_i = 32'h0;
    settle(); step_model();
    ext_i = 32'h00000100;
    settle(); step_model();
    rd(A_RIP, r); chk("R7", "no rise on disabled input", r, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule